// File: doc/BRIEF.md
# Wired-AND Bus Access Arbiter

Several devices share one open-drain upstream serial line and compete for the right to use its D and C/I channels. Each frame carries one arbitration octet. One bit of that octet tells every device whether the channels are free. The three lowest bits carry the address of a device that is trying to take the channels. A device that wants access checks the free/busy bit first. If the bit shows free, the device sends its programmed 3-bit address onto the line, most significant bit first, and reads each bit back. The line is wired-AND, so a device that sends a 1 and reads back a 0 has met a contender with a lower address. That device drops out at once.

A device that reads its whole address back without error owns the channels. In every following frame it pulls the free/busy bit low, until its host clears the request. When it lets go, it drops into a lower priority class. It may compete again only after it has seen the bus free in two frames in a row. If no device sends an address, the line floats high and reads as address 7. A device programmed with 7 therefore wins without ever pulling the line.

The host keeps the request input high for as long as it wants the channels. The frame timing logic supplies a frame-sync pulse and a strobe with a bit-slot index. The strobe marks the instant at which the line is sampled for that slot.

Top module: `wand_bus_arbiter`

## Requirements
- R1: `busy_o` holds the inverse of the free/busy bit as it was sampled at the latest strobe of slot `OCT_BASE+2` (octet bit 5, 1 = free). Its reset value is 0.
- R2: An idle device starts competing only at the free/busy strobe, and only when the request is high, no penalty is pending and the line reads 1. A 0 at that strobe keeps it off the address slots for the whole frame.
- R3: While the device is competing, it sends address bits 2, 1, 0 in slots `OCT_BASE+5`, `OCT_BASE+6` and `OCT_BASE+7`. `pull_dn_o` is high in such a slot exactly when the address bit for that slot is 0. The device drives no other slot while competing.
- R4: At each address slot the device compares the line sampled at the strobe with the bit it sent.
- R5: A device that sent a 1 and read back a 0 withdraws. It drives none of the remaining address slots of that frame and gets no grant.
- R6: `grant_o` rises after the strobe of the last address slot if every bit read back correctly. Among simultaneous contenders the lowest address wins. Address 7 with no contender wins without asserting `pull_dn_o`.
- R7: While it holds the grant and the request is high, the device pulls the free/busy slot low in every frame. It drives no address slot.
- R8: After the device leaves the granted state, it does not compete until it has sampled free/busy = 1 at two successive free/busy strobes with no 0 between them. It may compete from the frame after the second one.
- R9: While the request is low, `pull_dn_o` is low. A low request ends any arbitration, or any grant, by the next clock edge.
- R10: After reset the device is idle: no pull-down, no grant, busy 0, no penalty.
- R11: A device that lost arbitration may compete again in the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| frame_sync_i | input | 1 | One-cycle pulse at the start of each frame |
| slot_stb_i | input | 1 | One-cycle sample strobe at the end of the current bit slot |
| slot_idx_i | input | SLOT_W | Index of the current bit slot within the frame |
| line_i | input | 1 | Sampled level of the shared upstream line |
| req_i | input | 1 | Host request for access (level) |
| addr_i | input | ADDR_W | Programmed arbitration address |
| pull_dn_o | output | 1 | Pull-down enable for the open-drain line |
| grant_o | output | 1 | Access to the shared channels is held |
| busy_o | output | 1 | Last sampled free/busy bit showed occupied |

## Verification
The hardest state to reach from the ports is the penalty window. The device has to win, release, and then see a free/busy pattern in which isolated free frames are broken up by busy ones, so that a single free frame is shown not to be enough. The bench models a second device on the wired-AND line. That device can hold the bus for chosen frames or contend with a chosen address, and directed frames build the free–busy–free–free pattern straight after a release. Random frames then mix requests, releases, contention and foreign holds. A frame-level model predicts the pull-down in every slot, along with grant and busy.

// File: rtl/wand_arb_pkg.sv
package wand_arb_pkg;

  localparam int OCT_BITS = 8;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ARB,
    ST_LOST,
    ST_HOLD
  } arb_state_e;

  // slot index of a bit position inside the arbitration octet, sent MSB first
  function automatic int slot_of_bit(input int base, input int bit_pos);
    return base + (OCT_BITS - 1 - bit_pos);
  endfunction

endpackage

// File: rtl/wand_arb_slot_dec.sv
module wand_arb_slot_dec
  import wand_arb_pkg::*;
#(
  parameter int SLOT_W   = 6,
  parameter int ADDR_W   = 3,
  parameter int OCT_BASE = 16,
  parameter int IND_BIT  = 5,
  parameter int SEL_W    = (ADDR_W > 1) ? $clog2(ADDR_W) : 1
) (
  input  logic [SLOT_W-1:0] slot_idx_i,
  output logic              is_ind_o,
  output logic              is_addr_o,
  output logic [SEL_W-1:0]  addr_sel_o
);

  localparam int IND_SLOT = slot_of_bit(OCT_BASE, IND_BIT);

  logic [ADDR_W-1:0] hit;

  assign is_ind_o = (slot_idx_i == SLOT_W'(IND_SLOT));

  for (genvar g = 0; g < ADDR_W; g++) begin : g_hit
    localparam int BIT_SLOT = slot_of_bit(OCT_BASE, g);
    assign hit[g] = (slot_idx_i == SLOT_W'(BIT_SLOT));
  end

  assign is_addr_o = |hit;

  always_comb begin
    addr_sel_o = '0;
    for (int i = 0; i < ADDR_W; i++) begin
      if (hit[i]) addr_sel_o = SEL_W'(i);
    end
  end

endmodule

// File: rtl/wand_arb_penalty.sv
module wand_arb_penalty (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic smp_i,
  input  logic free_i,
  output logic pen_o
);

  logic seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pen_o  <= 1'b0;
      seen_q <= 1'b0;
    end else if (set_i) begin
      pen_o  <= 1'b1;
      seen_q <= 1'b0;
    end else if (pen_o && smp_i) begin
      if (!free_i)     seen_q <= 1'b0;
      else if (seen_q) pen_o  <= 1'b0;
      else             seen_q <= 1'b1;
    end
  end

  AST_PEN_TWO_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pen_o) |-> $past(seen_q && smp_i && free_i)); // R8

endmodule

// File: rtl/wand_arb_ctrl.sv
module wand_arb_ctrl
  import wand_arb_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int SEL_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fs_i,
  input  logic              stb_i,
  input  logic              line_i,
  input  logic              req_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              is_ind_i,
  input  logic              is_addr_i,
  input  logic [SEL_W-1:0]  addr_sel_i,
  input  logic              pen_i,
  output logic              pull_dn_o,
  output logic              grant_o,
  output logic              busy_o,
  output logic              hold_exit_o
);

  arb_state_e st_q;
  logic my_bit;
  logic ind_smp;
  logic bit_lost;

  assign my_bit   = addr_i[addr_sel_i];
  assign ind_smp  = stb_i && is_ind_i;
  assign bit_lost = stb_i && is_addr_i && my_bit && !line_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      busy_o <= 1'b0;
    end else begin
      if (ind_smp) busy_o <= !line_i;
      if (!req_i) begin
        st_q <= ST_IDLE;
      end else begin
        case (st_q)
          ST_IDLE: if (ind_smp && line_i && !pen_i) st_q <= ST_ARB;
          ST_ARB: begin
            if (fs_i) st_q <= ST_IDLE;
            else if (bit_lost) st_q <= ST_LOST;
            else if (stb_i && is_addr_i && addr_sel_i == '0) st_q <= ST_HOLD;
          end
          ST_LOST: if (fs_i) st_q <= ST_IDLE;
          default: ;
        endcase
      end
    end
  end

  assign grant_o     = (st_q == ST_HOLD);
  assign hold_exit_o = (st_q == ST_HOLD) && !req_i;
  assign pull_dn_o   = req_i && (((st_q == ST_HOLD) && is_ind_i) ||
                                 ((st_q == ST_ARB) && is_addr_i && !my_bit));

  AST_NO_DRIVE_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    !req_i |-> !pull_dn_o); // R9

  AST_NO_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IDLE && ind_smp && !line_i) |=> (st_q != ST_ARB)); // R2

  AST_LOSS_WITHDRAW: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_ARB && req_i && !fs_i && bit_lost) |=> (st_q == ST_LOST && !grant_o)); // R5

  AST_GRANT_LAST_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(grant_o) |-> $past(stb_i && is_addr_i && addr_sel_i == '0 && line_i == my_bit)); // R6

  AST_PEN_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (pen_i && st_q == ST_IDLE && ind_smp) |=> (st_q != ST_ARB)); // R8

  AST_HOLD_PULLS_IND: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_o && req_i && is_ind_i) |-> (pull_dn_o && !line_i)); // R7

endmodule

// File: rtl/wand_bus_arbiter.sv
module wand_bus_arbiter #(
  parameter int SLOT_W   = 6,
  parameter int ADDR_W   = 3,
  parameter int OCT_BASE = 16,
  parameter int IND_BIT  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_sync_i,
  input  logic              slot_stb_i,
  input  logic [SLOT_W-1:0] slot_idx_i,
  input  logic              line_i,
  input  logic              req_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              pull_dn_o,
  output logic              grant_o,
  output logic              busy_o
);

  localparam int SEL_W = (ADDR_W > 1) ? $clog2(ADDR_W) : 1;

  logic             is_ind;
  logic             is_addr;
  logic [SEL_W-1:0] addr_sel;
  logic             pen;
  logic             hold_exit;

  wand_arb_slot_dec #(
    .SLOT_W(SLOT_W), .ADDR_W(ADDR_W), .OCT_BASE(OCT_BASE),
    .IND_BIT(IND_BIT), .SEL_W(SEL_W)
  ) dec_i (
    .slot_idx_i(slot_idx_i),
    .is_ind_o  (is_ind),
    .is_addr_o (is_addr),
    .addr_sel_o(addr_sel)
  );

  wand_arb_penalty pen_i (
    .clk   (clk),
    .rst_n (rst_n),
    .set_i (hold_exit),
    .smp_i (slot_stb_i && is_ind),
    .free_i(line_i),
    .pen_o (pen)
  );

  wand_arb_ctrl #(.ADDR_W(ADDR_W), .SEL_W(SEL_W)) ctrl_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .fs_i       (frame_sync_i),
    .stb_i      (slot_stb_i),
    .line_i     (line_i),
    .req_i      (req_i),
    .addr_i     (addr_i),
    .is_ind_i   (is_ind),
    .is_addr_i  (is_addr),
    .addr_sel_i (addr_sel),
    .pen_i      (pen),
    .pull_dn_o  (pull_dn_o),
    .grant_o    (grant_o),
    .busy_o     (busy_o),
    .hold_exit_o(hold_exit)
  );

  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_n |=> (!grant_o && !busy_o)); // R10

endmodule

// File: tb/wand_bus_arbiter_tb_top.sv
`timescale 1ns/1ps
module wand_bus_arbiter_tb_top;

  localparam int SLOT_W = 6, ADDR_W = 3, OCT_BASE = 16, IND_BIT = 5;
  localparam int FRAME_SLOTS = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fs = 1'b0, stb = 1'b0, req = 1'b0;
  logic [SLOT_W-1:0] sidx = '0;
  logic [ADDR_W-1:0] addr = '0;
  logic o_pd = 1'b0;
  logic pd, grant, busy, line;

  int total = 0, bad = 0;

  // foreign device and frame-level model state
  bit o_busy, o_contend, o_active;
  logic [ADDR_W-1:0] o_addr;
  bit e_arb, e_hold, e_pen, e_seen, e_busy, e_lost;

  always #2.5 clk = ~clk;

  assign line = !(pd || o_pd);

  wand_bus_arbiter #(.SLOT_W(SLOT_W), .ADDR_W(ADDR_W), .OCT_BASE(OCT_BASE), .IND_BIT(IND_BIT)) dut_i (
    .clk(clk), .rst_n(rst_n), .frame_sync_i(fs), .slot_stb_i(stb), .slot_idx_i(sidx),
    .line_i(line), .req_i(req), .addr_i(addr), .pull_dn_o(pd), .grant_o(grant), .busy_o(busy));

  function automatic int ind_slot();
    return OCT_BASE + 7 - IND_BIT;
  endfunction

  // address bit carried by a slot, -1 if none; bits go out high to low
  function automatic int addr_bit_of(input int s);
    for (int b = 0; b < ADDR_W; b++)
      if (s == OCT_BASE + 7 - b) return b;
    return -1;
  endfunction

  function automatic bit want_pd(input int s);
    int b;
    b = addr_bit_of(s);
    if (!req) return 1'b0;
    if (s == ind_slot()) return e_hold;
    if (b >= 0) return e_arb && !addr[b];
    return 1'b0;
  endfunction

  task automatic chk(input bit act, input bit exp, input string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0b exp=%0b", tag, act, exp);
    end
  endtask

  task automatic release_req();
    req = 1'b0;
    if (e_hold) begin e_hold = 0; e_pen = 1; e_seen = 0; end
    e_arb = 0;
  endtask

  task automatic run_frame(input bit ob, input bit oc, input logic [ADDR_W-1:0] oa);
    bit pen_at_start;
    o_busy = ob; o_contend = oc; o_addr = oa; o_active = 0;
    e_arb = 0; e_lost = 0;
    pen_at_start = e_pen;
    for (int s = 0; s < FRAME_SLOTS; s++) begin
      int b;
      bit ln;
      @(negedge clk);
      sidx = SLOT_W'(s); fs = (s == 0); stb = 1'b0;
      b = addr_bit_of(s);
      if (s == ind_slot()) o_pd = o_busy;
      else if (b >= 0) o_pd = o_active && !o_addr[b];
      else o_pd = 1'b0;
      @(negedge clk);
      fs = 1'b0;
      if (!req)                 chk(pd, want_pd(s), "R9 pull-down with request low");
      else if (s == ind_slot()) chk(pd, want_pd(s), "R7 free/busy slot drive");
      else if (e_lost)          chk(pd, want_pd(s), "R5 drive after withdrawal");
      else                      chk(pd, want_pd(s), "R3 address slot drive");
      ln = line;
      stb = 1'b1;
      @(negedge clk);
      stb = 1'b0;
      if (s == ind_slot()) begin
        e_busy = !ln;
        if (!e_hold && req && !e_pen && ln) e_arb = 1; // R2
        if (e_pen) begin
          if (!ln) e_seen = 0;
          else if (e_seen) e_pen = 0;
          else e_seen = 1;
        end
        o_active = o_contend && ln;
      end else if (b >= 0) begin
        // R4: readback against the sent bit
        if (e_arb) begin
          if (addr[b] && !ln) begin e_arb = 0; e_lost = 1; end
          else if (b == 0) begin e_arb = 0; e_hold = 1; end
        end
        if (o_active && o_addr[b] && !ln) o_active = 0;
      end
    end
    @(negedge clk);
    chk(busy, e_busy, "R1 busy status");
    if (e_lost)            chk(grant, 1'b0, "R5 no grant after loss");
    else if (pen_at_start) chk(grant, e_hold, "R8 grant under penalty");
    else                   chk(grant, e_hold, "R6 grant after arbitration");
  endtask

  task automatic run_all();
    repeat (3) @(negedge clk);
    chk(pd, 1'b0, "R10 reset pull-down");
    chk(grant, 1'b0, "R10 reset grant");
    chk(busy, 1'b0, "R10 reset busy");
    rst_n = 1'b1;
    // address 7 alone wins without pulling (R6)
    req = 1'b1; addr = 3'd7;
    run_frame(0, 0, 0);
    chk(grant, 1'b1, "R6 address 7 default win");
    run_frame(0, 0, 0);               // holding, R7
    release_req();
    run_frame(0, 0, 0);               // first free
    req = 1'b1; addr = 3'd0;
    run_frame(1, 0, 0);               // busy breaks the run
    run_frame(0, 0, 0);               // free 1
    chk(grant, 1'b0, "R8 one free frame not enough");
    run_frame(0, 0, 0);               // free 2, clears penalty
    chk(grant, 1'b0, "R8 no compete in clearing frame");
    run_frame(0, 1, 3'd1);            // 0 beats 1
    chk(grant, 1'b1, "R6 lowest address wins");
    release_req();
    run_frame(0, 0, 0); run_frame(0, 0, 0);
    req = 1'b1; addr = 3'd5;
    run_frame(0, 1, 3'd2);            // 5 loses to 2
    chk(grant, 1'b0, "R5 higher address loses");
    run_frame(0, 0, 0);               // R11 competes next frame
    chk(grant, 1'b1, "R11 retry after loss");
    release_req();
    // constrained random frames
    for (int f = 0; f < 300; f++) begin
      bit ob, oc;
      logic [ADDR_W-1:0] oa;
      if ($urandom % 8 == 0) begin
        if (req) release_req(); else req = 1'b1;
      end
      if (!e_hold) addr = ADDR_W'($urandom);
      ob = !(e_hold && req) && ($urandom % 4 == 0);
      oa = ADDR_W'($urandom);
      oc = (oa != addr) && ($urandom % 2 == 0);
      run_frame(ob, oc, oa);
    end
  endtask

  initial begin
    void'($urandom(32'd1234));
    fork
      run_all();
      begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog act=timeout exp=done");
      end
    join_any
    disable fork;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule